// File: doc/BRIEF.md
# Capture/Compare General-Purpose Timer

A 32-bit up-counting timer that a host configures through a small synchronous register bus. Its count clock comes from one of four sources: none, the system clock, the system clock divided by 16, or rising edges of an external clock pin. An 8-bit prescaler then divides that source. When the counter equals a reference value on a count tick, the timer records a reference event. Depending on the mode, the counter then either goes back to zero or keeps counting. At the same time the timer toggles its compare pin or drives it low for one count period.

A capture pin is synchronised and watched for a programmable edge. On that edge the timer copies the counter into a capture register and records a capture event. Each pending event drives a level interrupt. The host can instead send events to a DMA request line, which the DMA side acknowledges. Software clears event flags by writing 1 to them.

Register word addresses on `busAddr`: 0 mode, 1 extended mode, 2 reference, 3 capture (read only), 4 counter, 5 events. Reads are combinational. A write takes effect at the clock edge where `busSel` and `busWr` are both high.

Top module: `cc_timer`

## Requirements
- R1: Mode bit 0 enables the timer. While it is 0, the counter, the prescaler and the divide-by-16 stage are held at zero, and `cmpOut` is held high. Reset leaves every register and event flag at zero, `cmpOut` high, and `irqOut` and `dmaReq` low.
- R2: Mode bits 2:1 select the count source. 00 gives no ticks, so the counter holds its value. 01 gives one tick per system clock. 10 gives one tick per 16 system clocks. 11 gives one tick per rising edge of `extClkIn` after a two-flop synchroniser.
- R3: Mode bits 15:8 hold P. The counter advances once every P+1 source ticks. After enabling with source 01, it reads floor(M/(P+1)) M cycles later. With source 10 it reads floor(floor(M/16)/(P+1)).
- R4: A reference event occurs on a count tick while the counter equals the reference register. If mode bit 3 is 1, that tick loads zero, so the counter cycles 0..ref. If mode bit 3 is 0, the counter keeps incrementing.
- R5: If mode bit 5 is 1, `cmpOut` toggles on each reference event. If mode bit 5 is 0, `cmpOut` goes low on a reference event and returns high on the next count tick.
- R6: Mode bits 7:6 choose the capture edge of `capIn`, which passes through two flip-flops before edge detection. 00 means none, 01 rising, 10 falling, 11 both. On a selected edge while enabled, the current counter value is loaded into the capture register.
- R7: Event register bit 0 is the capture flag and bit 1 is the reference flag. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. A new event in the same cycle wins over the clear.
- R8: With extended-mode bit 7 at 0, `irqOut` is high while the capture flag is set, or while the reference flag is set and mode bit 4 is 1.
- R9: With extended-mode bit 7 at 1, `irqOut` stays low. A capture event, or a reference event with mode bit 4 set, raises `dmaReq`. `dmaReq` stays high until `dmaAck` is seen. The acknowledge leaves the event flags unchanged.
- R10: Any write to the counter address clears the counter to zero, whatever data is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Register access select |
| busWr | input | 1 | Write strobe, qualified by busSel |
| busAddr | input | 3 | Register word address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr |
| extClkIn | input | 1 | External count clock pin |
| capIn | input | 1 | Capture trigger pin |
| dmaAck | input | 1 | DMA acknowledge, clears dmaReq |
| cmpOut | output | 1 | Compare output pin, idle high |
| irqOut | output | 1 | Level interrupt |
| dmaReq | output | 1 | DMA request |

## Verification
The assertions assume that `capIn` and `extClkIn` are asynchronous only up to the synchroniser. They also assume that no bus write lands in the same cycle as a `dmaAck` whose outcome is being checked. The bench drives both pins and all bus signals on the falling clock edge. It holds each pin level for at least three cycles, so every edge passes the synchronisers cleanly. Acknowledges are given only when the bus is idle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_MODE  = 3'd0;
  localparam logic [ADDR_W-1:0] A_XMODE = 3'd1;
  localparam logic [ADDR_W-1:0] A_REF   = 3'd2;
  localparam logic [ADDR_W-1:0] A_CAP   = 3'd3;
  localparam logic [ADDR_W-1:0] A_CNT   = 3'd4;
  localparam logic [ADDR_W-1:0] A_EVT   = 3'd5;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClr;
    logic cntTick;
    logic restart;
    logic capLoad;
  } tmrStrobe_t;
endpackage

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrobe_t       strb,
  input  logic [CNT_W-1:0] refVal,
  output logic [CNT_W-1:0] cntVal,
  output logic [CNT_W-1:0] capVal,
  output logic             match
);
  assign match = (cntVal == refVal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          cntVal <= '0;
    else if (strb.cntClr)               cntVal <= '0;
    else if (strb.cntTick) begin
      if (strb.restart && match)        cntVal <= '0;
      else                              cntVal <= cntVal + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             capVal <= '0;
    else if (strb.capLoad) capVal <= cntVal;
  end

  // R1 / R10: a clear strobe always leaves the counter at zero
  p_clear_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    strb.cntClr |=> (cntVal == '0));
  // R3: an ordinary tick adds exactly one
  p_step_one_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.cntTick && !strb.cntClr && !(strb.restart && match)) |=> (cntVal == $past(cntVal) + 1'b1));
  // R4: restart mode returns to zero on a match tick
  p_restart_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.cntTick && !strb.cntClr && strb.restart && match) |=> (cntVal == '0));
  // R6: capture register takes the counter value of the strobe cycle
  p_capture_copy_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.capLoad |=> (capVal == $past(cntVal)));
endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int PS_W   = 8,
  parameter int DIV    = 16,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [CNT_W-1:0]  busWdata,
  output logic [CNT_W-1:0]  busRdata,
  input  logic              extClkIn,
  input  logic              capIn,
  input  logic              dmaAck,
  input  logic [CNT_W-1:0]  cntVal,
  input  logic [CNT_W-1:0]  capVal,
  input  logic              match,
  output tmrStrobe_t        strb,
  output logic [CNT_W-1:0]  refVal,
  output logic              cmpOut,
  output logic              irqOut,
  output logic              dmaReq
);
  localparam int MODE_W = 8 + PS_W;
  localparam int DIV_W  = $clog2(DIV);

  logic [MODE_W-1:0] modeReg;
  logic              dmaRoute;
  logic [1:0]        evtFlags;
  logic [PS_W-1:0]   psCnt;
  logic [DIV_W-1:0]  divCnt;
  logic [SYNC_N-1:0] capSync, extSync;
  logic              capPrev, extPrev;

  wire busWe     = busSel && busWr;
  wire en        = modeReg[0];
  wire [1:0] src = modeReg[2:1];
  wire restartEn = modeReg[3];
  wire refReqEn  = modeReg[4];
  wire toggleOut = modeReg[5];
  wire [1:0] capEdge  = modeReg[7:6];
  wire [PS_W-1:0] psLimit = modeReg[8 +: PS_W];

  // input synchronisers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capSync <= '0; extSync <= '0; capPrev <= 1'b0; extPrev <= 1'b0;
    end else begin
      capSync <= {capSync[SYNC_N-2:0], capIn};
      extSync <= {extSync[SYNC_N-2:0], extClkIn};
      capPrev <= capSync[SYNC_N-1];
      extPrev <= extSync[SYNC_N-1];
    end
  end
  wire capRise = capSync[SYNC_N-1] && !capPrev;
  wire capFall = !capSync[SYNC_N-1] && capPrev;
  wire extRise = extSync[SYNC_N-1] && !extPrev;

  // source select and prescaler
  wire divTick = (divCnt == DIV_W'(DIV - 1));
  logic srcTick;
  always_comb begin
    case (src)
      2'b01:   srcTick = 1'b1;
      2'b10:   srcTick = divTick;
      2'b11:   srcTick = extRise;
      default: srcTick = 1'b0;
    endcase
  end
  wire psWrap    = (psCnt >= psLimit);
  wire countTick = en && srcTick && psWrap;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0; psCnt <= '0;
    end else if (!en) begin
      divCnt <= '0; psCnt <= '0;
    end else begin
      divCnt <= divCnt + 1'b1;
      if (srcTick) psCnt <= psWrap ? '0 : psCnt + 1'b1;
    end
  end

  wire capEvt = en && ((capEdge[0] && capRise) || (capEdge[1] && capFall));
  wire refHit = countTick && match;

  always_comb begin
    strb.cntClr  = !en || (busWe && busAddr == A_CNT);
    strb.cntTick = countTick;
    strb.restart = restartEn;
    strb.capLoad = capEvt;
  end

  // registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg <= '0; dmaRoute <= 1'b0; refVal <= '0;
    end else if (busWe) begin
      case (busAddr)
        A_MODE:  modeReg  <= busWdata[MODE_W-1:0];
        A_XMODE: dmaRoute <= busWdata[7];
        A_REF:   refVal   <= busWdata;
        default: ;
      endcase
    end
  end

  wire evtWe = busWe && (busAddr == A_EVT);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) evtFlags <= '0;
    else begin
      if (capEvt)                  evtFlags[0] <= 1'b1;
      else if (evtWe && busWdata[0]) evtFlags[0] <= 1'b0;
      if (refHit)                  evtFlags[1] <= 1'b1;
      else if (evtWe && busWdata[1]) evtFlags[1] <= 1'b0;
    end
  end

  // compare pin
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        cmpOut <= 1'b1;
    else if (!en)                     cmpOut <= 1'b1;
    else if (refHit)                  cmpOut <= toggleOut ? !cmpOut : 1'b0;
    else if (countTick && !toggleOut) cmpOut <= 1'b1;
  end

  // requests
  wire request = evtFlags[0] || (evtFlags[1] && refReqEn);
  assign irqOut = request && !dmaRoute;
  wire dmaSet = dmaRoute && (capEvt || (refHit && refReqEn));
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       dmaReq <= 1'b0;
    else if (dmaSet) dmaReq <= 1'b1;
    else if (dmaAck) dmaReq <= 1'b0;
  end

  always_comb begin
    case (busAddr)
      A_MODE:  busRdata = CNT_W'(modeReg);
      A_XMODE: busRdata = CNT_W'({dmaRoute, 7'b0});
      A_REF:   busRdata = refVal;
      A_CAP:   busRdata = capVal;
      A_CNT:   busRdata = cntVal;
      A_EVT:   busRdata = CNT_W'(evtFlags);
      default: busRdata = '0;
    endcase
  end

  // R5: pulse mode drives the pin low after a reference event
  p_pulse_low_r5: assert property (@(posedge clk) disable iff (!rstN)
    (en && !toggleOut && refHit) |=> !cmpOut);
  // R7: write-one clears the reference flag when no event competes
  p_w1c_ref_r7: assert property (@(posedge clk) disable iff (!rstN)
    (evtWe && busWdata[1] && !refHit) |=> !evtFlags[1]);
  // R8: interrupt only with a pending flag
  p_irq_flag_r8: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (evtFlags != 2'b00));
  // R9: acknowledge drops the request
  p_dma_ack_r9: assert property (@(posedge clk) disable iff (!rstN)
    (dmaAck && !dmaSet) |=> !dmaReq);
endmodule

// File: rtl/cc_timer.sv
module cc_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PS_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [CNT_W-1:0]  busWdata,
  output logic [CNT_W-1:0]  busRdata,
  input  logic              extClkIn,
  input  logic              capIn,
  input  logic              dmaAck,
  output logic              cmpOut,
  output logic              irqOut,
  output logic              dmaReq
);
  tmrStrobe_t       strb;
  logic [CNT_W-1:0] cntVal, capVal, refVal;
  logic             match;

  tmr_ctrl #(.CNT_W(CNT_W), .PS_W(PS_W), .DIV(16), .SYNC_N(2)) u_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .extClkIn(extClkIn), .capIn(capIn),
    .dmaAck(dmaAck), .cntVal(cntVal), .capVal(capVal), .match(match), .strb(strb),
    .refVal(refVal), .cmpOut(cmpOut), .irqOut(irqOut), .dmaReq(dmaReq)
  );

  tmr_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .refVal(refVal),
    .cntVal(cntVal), .capVal(capVal), .match(match)
  );
endmodule

// File: tb/cc_timer_bench.sv
module cc_timer_bench;
  import tmr_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busSel = 1'b0, busWr = 1'b0;
  logic [2:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic extClkIn = 1'b0, capIn = 1'b0, dmaAck = 1'b0;
  logic cmpOut, irqOut, dmaReq;
  int nChk = 0, nBad = 0;
  logic [31:0] rd, vHold;

  always #(CLK_PERIOD/2) clk = ~clk;

  cc_timer u_cc_timer (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .extClkIn(extClkIn), .capIn(capIn),
    .dmaAck(dmaAck), .cmpOut(cmpOut), .irqOut(irqOut), .dmaReq(dmaReq)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic busWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk);
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic busRead(input logic [2:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChk++; nBad++;
    $display("FAIL R1 watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    busRead(A_CNT, rd);  chk("R1", "reset counter", rd, 0);
    busRead(A_MODE, rd); chk("R1", "reset mode", rd, 0);
    busRead(A_EVT, rd);  chk("R1", "reset events", rd, 0);
    chk("R1", "reset cmpOut", 32'(cmpOut), 1);
    chk("R1", "reset irq", 32'(irqOut), 0);
    chk("R1", "reset dmaReq", 32'(dmaReq), 0);

    busWrite(A_REF, 32'hFFFF_FFFF);
    // R3 system clock with prescaler sweep
    for (int p = 0; p < 6; p++) begin
      busWrite(A_MODE, 0);
      busWrite(A_MODE, 32'(p << 8) | 32'h3);
      for (int m = 1; m <= 4 * (p + 1) + 1; m++) begin
        @(negedge clk);
        busRead(A_CNT, rd);
        chk("R3", "sysclk count", rd, 32'(m / (p + 1)));
      end
    end
    // R2 divide-by-16 source
    for (int p = 0; p < 2; p++) begin
      busWrite(A_MODE, 0);
      busWrite(A_MODE, 32'(p << 8) | 32'h5);
      for (int m = 1; m <= 100; m++) begin
        @(negedge clk);
        busRead(A_CNT, rd);
        chk("R2", "div16 count", rd, 32'((m / 16) / (p + 1)));
      end
    end
    // R2 external clock source, P=1
    busWrite(A_MODE, 0);
    busWrite(A_MODE, 32'h107);
    for (int i = 1; i <= 6; i++) begin
      extClkIn = 1'b1; repeat (3) @(negedge clk);
      extClkIn = 1'b0; repeat (3) @(negedge clk);
      busRead(A_CNT, rd);
      chk("R2", "ext clock count", rd, 32'(i / 2));
    end
    // R10 counter write clears
    busWrite(A_MODE, 0);
    busWrite(A_MODE, 32'h3);
    repeat (5) @(negedge clk);
    busWrite(A_CNT, 32'h1234);
    busRead(A_CNT, rd); chk("R10", "counter after write", rd, 0);
    @(negedge clk);
    busRead(A_CNT, rd); chk("R10", "counter restarts", rd, 1);
    // R2 stop source holds
    repeat (4) @(negedge clk);
    busWrite(A_MODE, 32'h1);
    busRead(A_CNT, vHold);
    repeat (5) @(negedge clk);
    busRead(A_CNT, rd); chk("R2", "stopped counter holds", rd, vHold);
    chk("R2", "stopped value nonzero", 32'(vHold != 0), 1);

    // R6 capture edge select, counter frozen at vHold
    for (int e = 0; e < 4; e++) begin
      busWrite(A_MODE, 32'h1 | 32'(e << 6));
      busWrite(A_EVT, 32'h3);
      capIn = 1'b1; repeat (4) @(negedge clk);
      busRead(A_EVT, rd); chk("R6", "flag after rise", rd & 1, 32'(e & 1));
      capIn = 1'b0; repeat (4) @(negedge clk);
      busRead(A_EVT, rd); chk("R6", "flag after fall", rd & 1, 32'(e != 0));
      chk("R8", "irq from capture", 32'(irqOut), 32'(e != 0));
      busRead(A_CAP, rd); chk("R6", "capture value", rd, (e == 0) ? 32'h0 : vHold);
    end
    busWrite(A_EVT, 32'h1);
    chk("R7", "capture flag cleared irq", 32'(irqOut), 0);

    // R4 restart sweep
    for (int r = 0; r < 5; r++) begin
      busWrite(A_MODE, 0);
      busWrite(A_REF, 32'(r));
      busWrite(A_EVT, 32'h3);
      busWrite(A_MODE, 32'h0B);
      for (int m = 1; m <= 3 * (r + 1); m++) begin
        @(negedge clk);
        busRead(A_CNT, rd); chk("R4", "restart count", rd, 32'(m % (r + 1)));
        busRead(A_EVT, rd);
        if (m == r) chk("R4", "no event before match", rd & 2, 0);
        if (m == r + 1) chk("R4", "event at match", rd & 2, 2);
      end
    end
    // R5 toggle mode, ref=2
    busWrite(A_MODE, 0);
    busWrite(A_REF, 32'd2);
    busWrite(A_MODE, 32'h2B);
    for (int m = 1; m <= 10; m++) begin
      @(negedge clk);
      chk("R5", "toggle pin", 32'(cmpOut), 32'(((m / 3) % 2) == 0));
    end
    // R1 disable resets and holds
    busWrite(A_MODE, 0);
    chk("R1", "pin high when disabled", 32'(cmpOut), 1);
    repeat (5) @(negedge clk);
    busRead(A_CNT, rd); chk("R1", "counter held at zero", rd, 0);
    // R5 pulse mode, P=1, ref=2
    busWrite(A_MODE, 32'h10B);
    for (int m = 1; m <= 20; m++) begin
      @(negedge clk);
      chk("R5", "pulse pin", 32'(cmpOut), 32'(!(m >= 6 && (m % 6) < 2)));
    end

    // R4 free run, ref=3
    busWrite(A_MODE, 0);
    busWrite(A_REF, 32'd3);
    busWrite(A_EVT, 32'h3);
    busWrite(A_MODE, 32'h03);
    for (int m = 1; m <= 10; m++) begin
      @(negedge clk);
      busRead(A_CNT, rd); chk("R4", "free-run count", rd, 32'(m));
    end
    busRead(A_EVT, rd); chk("R4", "free-run event", rd, 2);
    chk("R8", "irq masked without bit4", 32'(irqOut), 0);
    busWrite(A_MODE, 32'h13);
    chk("R8", "irq with bit4", 32'(irqOut), 1);
    busWrite(A_EVT, 32'h1);
    busRead(A_EVT, rd); chk("R7", "writing bit0 keeps ref flag", rd, 2);
    busWrite(A_EVT, 32'h2);
    busRead(A_EVT, rd); chk("R7", "writing bit1 clears", rd, 0);
    chk("R8", "irq after clear", 32'(irqOut), 0);

    // R9 DMA routing
    busWrite(A_MODE, 0);
    busWrite(A_XMODE, 32'h80);
    busWrite(A_MODE, 32'h13);
    repeat (6) @(negedge clk);
    chk("R9", "dma request", 32'(dmaReq), 1);
    chk("R9", "irq suppressed", 32'(irqOut), 0);
    dmaAck = 1'b1; @(negedge clk); dmaAck = 1'b0;
    chk("R9", "dma after ack", 32'(dmaReq), 0);
    busRead(A_EVT, rd); chk("R9", "flag kept after ack", rd, 2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule